// File: doc/BRIEF.md
# Sliding-Window Z-Score Normalizer

This block turns a stream of timestamped signed samples into a stream of locally standardized scores. Each sample is scored against a centred window of `N = 2H+1` neighbouring samples: the score is the sample minus the window mean, divided by the window's population standard deviation. Offset and gain drift slowly compared with the window, so local statistics stand in for global ones. The output is reduced to a narrow fixed-point score (two integer bits, thirteen fraction bits) and a narrow timestamp. Downstream pattern-matching stages can then compare shapes regardless of level or scale.

Window sum and sum of squares are kept in wide accumulators. They are updated on every accepted sample by adding the newcomer and removing the sample that drops out. Division by N is avoided by scaling: the score is `(N·x − S) / isqrt(N·Q − S²)`, which equals `(x − mean)/std`. A serial square-root engine and a serial divider share one datapath. The stream has a valid strobe only, and successive samples must be at least LAT = 88 clock cycles apart (default parameters). The half-width H comes from a configuration input that is captured while reset is held.

Top module: `win_znorm`

## Requirements
- R1: While reset is asserted and until N samples have been accepted since reset, `out_valid` stays low. The sample that brings the count to N is the first to produce a result.
- R2: H is taken from `cfg_half` during reset: 0 becomes 1, values above HMAX (8) become HMAX. Changes to `cfg_half` after reset have no effect on the window length.
- R3: The result value equals `trunc0((N·xc − S)·2^13 / max(isqrt(N·Q − S²), 1))`, then saturated (R7). Here S and Q are the sum and sum of squares of the last N accepted samples, xc is the sample accepted H samples before the newest, isqrt rounds down, and trunc0 truncates toward zero. The value is a two's-complement 16-bit word with 13 fraction bits.
- R4: `out_time` equals the low 16 bits of the timestamp of the centre sample xc.
- R5: For each sample that produces a result, `out_valid` is high for exactly one cycle. It rises 88 clock edges after the edge that accepts the sample (1 load edge + 37 root steps + 50 divide steps).
- R6: A window of identical samples yields a result of exactly 0: the standard deviation is clamped to a nonzero floor.
- R7: Results above +32767 are output as +32767, and results below −32768 as −32768.
- R8: After the window first fills, every accepted sample yields one result. The window slides by one sample per input, and the oldest sample leaves the statistics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; `cfg_half` is captured while high |
| cfg_half | input | 4 | Window half-width H |
| in_valid | input | 1 | Sample strobe |
| in_value | input | 32 | Signed sample value |
| in_time | input | 32 | Sample timestamp |
| out_valid | output | 1 | Result strobe |
| out_value | output | 16 | Signed score, 13 fraction bits |
| out_time | output | 16 | Low timestamp bits of the scored sample |

## Verification
Every result is due 88 rising edges after the edge that accepted its triggering sample. The bench drives each sample at a falling edge. It then counts falling edges one by one and records the exact count at which `out_valid` appears, so an early, late or doubled pulse is reported. Samples that must not produce a result are watched for the same window plus a margin. The next sample is issued only after that window, which honours the input spacing. Reference scores come from a wide-integer model of the requirement formula, built over the bench's own history of the samples it sent.

// File: rtl/win_znorm.sv
`timescale 1ns/1ps
module win_znorm #(
  parameter int VAL_W   = 32,
  parameter int TIME_W  = 32,
  parameter int OUT_W   = 16,
  parameter int OTIME_W = 16,
  parameter int FRAC    = 13,
  parameter int HMAX    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(HMAX+1)-1:0] cfg_half,
  input  logic                      in_valid,
  input  logic signed [VAL_W-1:0]   in_value,
  input  logic [TIME_W-1:0]         in_time,
  output logic                      out_valid,
  output logic signed [OUT_W-1:0]   out_value,
  output logic [OTIME_W-1:0]        out_time
);
  localparam int DEPTH = 2*HMAX + 1;
  localparam int HB    = $clog2(HMAX+1);
  localparam int NB    = HB + 1;
  localparam int SW    = VAL_W + NB;
  localparam int QW    = 2*VAL_W + NB;
  localparam int VW    = 2*VAL_W + 2*NB;
  localparam int RW    = VW / 2;
  localparam int NUMW  = VAL_W + NB + 1;
  localparam int MW    = NUMW - 1 + FRAC;
  localparam int CW    = $clog2(MW + RW);

  typedef enum logic [1:0] {IDLE, ROOT, DIV} st_t;

  logic signed [VAL_W-1:0] vline [DEPTH];
  logic [TIME_W-1:0]       tline [DEPTH];
  logic [HB-1:0]           hcfg;
  logic [NB-1:0]           fill;
  logic signed [SW-1:0]    wsum;
  logic [QW-1:0]           wsq;
  logic                    go;
  st_t                     state;
  logic [CW-1:0]           cnt;
  logic [VW-1:0]           rad;
  logic [RW+2:0]           rrem;
  logic [RW-1:0]           root;
  logic [RW-1:0]           drem;
  logic [MW-1:0]           dvd;
  logic                    neg;
  logic [OTIME_W-1:0]      tsc;

  wire [NB-1:0] nwin = {hcfg, 1'b1};
  wire [NB-1:0] cidx = {1'b0, hcfg};
  wire signed [VAL_W-1:0] oldest = vline[nwin - 1'b1];
  wire [2*VAL_W-1:0] sq_new = in_value * in_value;
  wire [2*VAL_W-1:0] sq_old = oldest * oldest;

  wire signed [NUMW-1:0] nw_s  = NUMW'(nwin);
  wire signed [NUMW-1:0] c_s   = NUMW'(vline[cidx]);
  wire signed [NUMW-1:0] num_s = nw_s * c_s - NUMW'(wsum);
  wire [NUMW-1:0] num_abs = num_s[NUMW-1] ? -num_s : num_s;
  wire signed [VW-1:0] ws_e = VW'(wsum);
  wire [VW-1:0] s2   = ws_e * ws_e;
  wire [VW-1:0] varv = VW'(nwin) * VW'(wsq) - s2;

  wire [RW+2:0] rtry = {rrem[RW:0], rad[VW-1 -: 2]};
  wire [RW+2:0] rtri = {1'b0, root, 2'b01};
  wire          rbit = rtry >= rtri;

  wire [RW-1:0] dv   = (root == '0) ? RW'(1) : root;
  wire [RW:0]   dtry = {drem, dvd[MW-1]};
  wire          dbit = dtry >= {1'b0, dv};
  wire [MW-1:0] qfin = {dvd[MW-2:0], dbit};
  wire [MW-1:0] lim  = neg ? MW'(2**(OUT_W-1)) : MW'(2**(OUT_W-1) - 1);
  wire [MW-1:0] qs   = (qfin > lim) ? lim : qfin;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcfg <= (cfg_half == '0) ? HB'(1) : ((cfg_half > HB'(HMAX)) ? HB'(HMAX) : cfg_half);
      for (int i = 0; i < DEPTH; i++) begin
        vline[i] <= '0;
        tline[i] <= '0;
      end
      fill <= '0;
      wsum <= '0;
      wsq  <= '0;
      go   <= 1'b0;
    end else begin
      go <= 1'b0;
      if (in_valid) begin
        vline[0] <= in_value;
        tline[0] <= in_time;
        for (int i = 1; i < DEPTH; i++) begin
          vline[i] <= vline[i-1];
          tline[i] <= tline[i-1];
        end
        wsum <= wsum + SW'(in_value) - SW'(oldest);
        wsq  <= wsq + QW'(sq_new) - QW'(sq_old);
        if (fill != nwin) fill <= fill + 1'b1;
        go <= (fill == nwin) || (fill + 1'b1 == nwin);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= IDLE; cnt <= '0; rad <= '0; rrem <= '0; root <= '0;
      drem <= '0; dvd <= '0; neg <= 1'b0; tsc <= '0;
      out_valid <= 1'b0; out_value <= '0; out_time <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        IDLE: if (go) begin
          rad   <= varv;
          rrem  <= '0;
          root  <= '0;
          neg   <= num_s[NUMW-1];
          dvd   <= {num_abs[NUMW-2:0], FRAC'(0)};
          tsc   <= tline[cidx][OTIME_W-1:0];
          cnt   <= '0;
          state <= ROOT;
        end
        ROOT: begin
          rrem <= rbit ? rtry - rtri : rtry;
          root <= {root[RW-2:0], rbit};
          rad  <= rad << 2;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(RW-1)) begin
            cnt   <= '0;
            drem  <= '0;
            state <= DIV;
          end
        end
        DIV: begin
          drem <= dbit ? RW'(dtry - {1'b0, dv}) : RW'(dtry);
          dvd  <= qfin;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(MW-1)) begin
            out_valid <= 1'b1;
            out_value <= neg ? OUT_W'(-qs) : OUT_W'(qs);
            out_time  <= tsc;
            state     <= IDLE;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R5
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);
  // R1
  fill_gate_chk: assert property (@(posedge clk) disable iff (rst) out_valid |-> fill == nwin);
  // R8
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst) fill == nwin |=> fill == nwin);
  // R2
  hcfg_hold_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> $stable(hcfg));
  // R5
  go_idle_chk: assert property (@(posedge clk) disable iff (rst) go |-> state == IDLE);
endmodule

// File: tb/sim_win_znorm.sv
`timescale 1ns/1ps
module sim_win_znorm;
  localparam int HMAX = 8;
  localparam int NBB  = $clog2(HMAX + 1) + 1;
  localparam int RWB  = (2*32 + 2*NBB) / 2;
  localparam int MWB  = 32 + NBB + 13;
  localparam int LAT  = 1 + RWB + MWB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] cfg_half = 4'd2;
  logic in_valid = 1'b0;
  logic signed [31:0] in_value = '0;
  logic [31:0] in_time = '0;
  logic out_valid;
  logic signed [15:0] out_value;
  logic [15:0] out_time;

  int nvec = 0;
  int nbad = 0;
  int heff = 2;
  logic signed [31:0] hv[$];
  logic [31:0] ht[$];

  always #2.5 clk = ~clk;

  win_znorm u0 (.clk(clk), .rst(rst), .cfg_half(cfg_half), .in_valid(in_valid),
                .in_value(in_value), .in_time(in_time), .out_valid(out_valid),
                .out_value(out_value), .out_time(out_time));

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [127:0] isqrt(input logic signed [127:0] v);
    logic signed [127:0] r = 0;
    logic signed [127:0] t;
    for (int b = 44; b >= 0; b--) begin
      t = r | (128'sd1 <<< b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  function automatic logic signed [15:0] model();
    logic signed [127:0] s = 0, q = 0, n, v, d, num, z, x;
    int k = hv.size();
    n = 2*heff + 1;
    for (int i = k - (2*heff + 1); i < k; i++) begin
      x = hv[i];
      s += x;
      q += x * x;
    end
    v = n * q - s * s;
    d = isqrt(v);
    if (d == 0) d = 1;
    x = hv[k-1-heff];
    num = (n * x - s) * 8192;
    z = num / d;
    if (z > 32767) z = 32767;
    if (z < -32768) z = -32768;
    return z[15:0];
  endfunction

  task automatic rst_with(input logic [3:0] h);
    cfg_half = h;
    heff = (h == 0) ? 1 : ((h > HMAX) ? HMAX : h);
    hv.delete();
    ht.delete();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cfg_half = 4'd5;
  endtask

  task automatic send(input logic signed [31:0] v, input logic [31:0] t, input string tag);
    int seen_at = -1;
    int pulses = 0;
    logic signed [15:0] gv = '0;
    logic [15:0] gt = '0;
    logic expect_out;
    hv.push_back(v);
    ht.push_back(t);
    expect_out = hv.size() >= 2*heff + 1;
    in_valid = 1'b1; in_value = v; in_time = t;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i <= LAT + 4; i++) begin
      @(negedge clk);
      if (out_valid) begin
        pulses++;
        if (seen_at < 0) begin seen_at = i; gv = out_value; gt = out_time; end
      end
    end
    if (expect_out) begin
      chk(seen_at == LAT && pulses == 1, "R5 latency", seen_at, LAT);
      chk(gv == model(), tag, gv, model());
      chk(gt == ht[hv.size()-1-heff][15:0], "R4 time", gt, ht[hv.size()-1-heff][15:0]);
    end else begin
      chk(pulses == 0, "R1 no output before fill", pulses, 0);
    end
  endtask

  task automatic t_reset();
    rst_with(4'd2);
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    chk(out_value == 16'sd0, "R1 reset value", out_value, 0);
  endtask

  task automatic t_slide();
    rst_with(4'd2);
    send(100, 32'h0001_0010, "R3 fill");
    send(-50, 32'h0001_0011, "R3 fill");
    send(300, 32'h0001_0012, "R3 fill");
    send(7, 32'h0001_0013, "R3 fill");
    send(-1000, 32'h0001_0014, "R3 first");
    for (int i = 0; i < 20; i++)
      send(32'(((i*7919) % 2001 - 1000) * 4096), 32'h0002_0000 + 32'(i), "R8 slide");
  endtask

  task automatic t_flat();
    rst_with(4'd3);
    for (int i = 0; i < 10; i++) begin
      send(123456, 32'h0003_0000 + 32'(i), "R6 flat");
      if (hv.size() >= 7) chk(model() == 0, "R6 model", model(), 0);
    end
  endtask

  task automatic t_sat();
    rst_with(4'd8);
    for (int i = 0; i < 8; i++) send(0, 32'(i), "R7 pre");
    send(1000, 32'h0000_0aaa, "R7");
    for (int i = 0; i < 8; i++) send(0, 32'(20 + i), "R7 pos");
    rst_with(4'd8);
    for (int i = 0; i < 8; i++) send(0, 32'(i), "R7 pre");
    send(-1000, 32'h0000_0bbb, "R7");
    for (int i = 0; i < 8; i++) send(0, 32'(20 + i), "R7 neg");
  endtask

  task automatic t_cfg();
    rst_with(4'd0);
    send(5, 1, "R2 zero");
    send(-9, 2, "R2 zero");
    send(40, 3, "R2 zero");
    rst_with(4'd15);
    for (int i = 0; i < 17; i++) send(32'(i * i - 60), 32'(100 + i), "R2 clamp");
  endtask

  task automatic t_extreme();
    rst_with(4'd1);
    send(32'sh7fff_ffff, 32'hdead_0001, "R3 wide");
    send(32'sh8000_0000, 32'hdead_0002, "R3 wide");
    send(32'sh7fff_ffff, 32'hdead_0003, "R3 wide");
    send(32'sh8000_0000, 32'hdead_0004, "R3 wide");
  endtask

  initial begin
    t_reset();
    t_slide();
    t_flat();
    t_sat();
    t_cfg();
    t_extreme();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule